// File: doc/BRIEF.md
# Effective Address and PC Source Unit

This block forms every effective address and every next program-counter value for a 16-bit word-addressed processor. One adder serves all of them. Its base operand is either the current PC or a value read from the register file. Its offset operand is either zero or a sign-extended field of the instruction word: the low 6 bits, the low 9 bits or the low 11 bits. The sum goes to two places. It is one input of the PC source mux, and it is one input of the mux that supplies the memory address register.

The block also holds the PC register. The PC loads only when control raises the load enable. It can load the incremented PC, a value from the shared data bus, or the adder sum. Memory holds one 16-bit word per address, so the fetch step advances the PC by exactly 1. The memory-address mux picks either the adder sum or the low 8 bits of the instruction, zero-extended, for trap-vector lookups.

All select and enable pins are plain control levels driven by an external sequencer. The block has no handshake and does no buffering: the address outputs are combinational, and the PC changes only on a clock edge.

Top module: `eapc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc` equals START_ADDR (default 16'h3000).
- R2: `ea` is the base operand plus an offset, modulo 2^16, in the same cycle. The offset is chosen by `off_sel`: 2'b00 gives zero, 2'b01 gives sign-extended `ir[5:0]`, 2'b10 gives sign-extended `ir[8:0]`, and 2'b11 gives sign-extended `ir[10:0]`.
- R3: `base_sel` = 0 makes the base operand the current `pc` register value; `base_sel` = 1 makes it `reg_base`.
- R4: While `pc_load` is low, `pc` keeps its value across clock edges, whatever the other inputs are.
- R5: With `pc_load` high and `pc_sel` equal to 2'b00 or 2'b11, the next `pc` is `pc` + 1, and 16'hFFFF wraps to 16'h0000.
- R6: With `pc_load` high and `pc_sel` = 2'b01, the next `pc` is `bus_in`.
- R7: With `pc_load` high and `pc_sel` = 2'b10, the next `pc` is the `ea` value present before the edge.
- R8: `addr_sel` = 0 makes `mar_addr` equal to `ea`; `addr_sel` = 1 makes it {8'h00, `ir[7:0]`}. Both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir | input | 16 | Current instruction word |
| reg_base | input | 16 | Register-file read value used as a base |
| bus_in | input | 16 | Shared data bus value for PC loads |
| base_sel | input | 1 | Base operand select: 0 PC, 1 register value |
| off_sel | input | 2 | Offset select: 00 zero, 01 6-bit, 10 9-bit, 11 11-bit |
| pc_sel | input | 2 | PC source: 00/11 PC+1, 01 bus, 10 adder sum |
| pc_load | input | 1 | PC load enable |
| addr_sel | input | 1 | Memory-address source: 0 adder sum, 1 trap vector |
| pc | output | 16 | Program counter register |
| ea | output | 16 | Adder sum (effective address / branch target) |
| mar_addr | output | 16 | Value offered to the memory address register |

## Verification
`ea` and `mar_addr` are combinational, so each is due in the same cycle as its inputs. The bench drives inputs just after a falling edge and samples these outputs 1 ns later. The PC update is due at the first rising edge after the load request: the bench computes the expected value from the inputs and the model PC before that edge, then samples `pc` 1 ns after it. Random vectors cover every select combination. Directed cases cover the 16'hFFFF wrap, all-ones offsets for each width, trap vectors taken from words with the upper bits set, and holds while the bus toggles.

// File: rtl/eapc_pkg.sv
package eapc_pkg;
  typedef enum logic [1:0] {
    OFF_ZERO  = 2'b00,
    OFF_SHORT = 2'b01,
    OFF_MID   = 2'b10,
    OFF_LONG  = 2'b11
  } off_sel_e;

  typedef enum logic [1:0] {
    PCS_INC  = 2'b00,
    PCS_BUS  = 2'b01,
    PCS_SUM  = 2'b10,
    PCS_INC2 = 2'b11
  } pc_sel_e;
endpackage

// File: rtl/eapc_offset_gen.sv
module eapc_offset_gen
  import eapc_pkg::*;
#(
  parameter int W       = 16,
  parameter int SHORT_W = 6,
  parameter int MID_W   = 9,
  parameter int LONG_W  = 11
) (
  input  logic [W-1:0] instr,
  input  logic [1:0]   sel,
  output logic [W-1:0] offset
);
  localparam int NCAND = 3;

  logic [W-1:0] cand [NCAND];

  for (genvar g = 0; g < NCAND; g++) begin : g_sext
    localparam int FW = (g == 0) ? SHORT_W : ((g == 1) ? MID_W : LONG_W);
    assign cand[g] = {{(W-FW){instr[FW-1]}}, instr[FW-1:0]};
  end

  always_comb begin
    unique case (off_sel_e'(sel))
      OFF_ZERO:  offset = '0;
      OFF_SHORT: offset = cand[0];
      OFF_MID:   offset = cand[1];
      default:   offset = cand[2];
    endcase
  end
endmodule

// File: rtl/eapc_adder.sv
module eapc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] reg_base,
  input  logic         base_sel,
  input  logic [W-1:0] offset,
  output logic [W-1:0] sum
);
  logic [W-1:0] base;

  always_comb begin
    base = base_sel ? reg_base : pc;
    sum  = base + offset;
  end
endmodule

// File: rtl/eapc_pc_reg.sv
module eapc_pc_reg
  import eapc_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [15:0] START_ADDR = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [1:0]   sel,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] sum,
  output logic [W-1:0] pc
);
  localparam logic [W-1:0] RST_PC = W'(START_ADDR);

  logic [W-1:0] pc_nxt;

  always_comb begin
    unique case (pc_sel_e'(sel))
      PCS_BUS: pc_nxt = bus_in;
      PCS_SUM: pc_nxt = sum;
      default: pc_nxt = pc + W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= RST_PC;
    else if (load) pc <= pc_nxt;
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pc));
  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (sel == 2'b00 || sel == 2'b11)) |=> pc == $past(pc) + W'(1));
  a_r6_bus_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel == 2'b01) |=> pc == $past(bus_in));
  a_r7_sum_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel == 2'b10) |=> pc == $past(sum));
endmodule

// File: rtl/eapc_addr_mux.sv
module eapc_addr_mux #(
  parameter int W     = 16,
  parameter int TRAPW = 8
) (
  input  logic [W-1:0] sum,
  input  logic [W-1:0] instr,
  input  logic         sel,
  output logic [W-1:0] mar_addr
);
  always_comb begin
    mar_addr = sel ? {{(W-TRAPW){1'b0}}, instr[TRAPW-1:0]} : sum;
  end

  always_comb begin
    if (sel) a_r8_trap_upper_zero: assert (mar_addr[W-1:TRAPW] == '0);
  end
endmodule

// File: rtl/eapc_unit.sv
module eapc_unit #(
  parameter int          W          = 16,
  parameter int          SHORT_W    = 6,
  parameter int          MID_W      = 9,
  parameter int          LONG_W     = 11,
  parameter int          TRAPW      = 8,
  parameter logic [15:0] START_ADDR = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ir,
  input  logic [W-1:0] reg_base,
  input  logic [W-1:0] bus_in,
  input  logic         base_sel,
  input  logic [1:0]   off_sel,
  input  logic [1:0]   pc_sel,
  input  logic         pc_load,
  input  logic         addr_sel,
  output logic [W-1:0] pc,
  output logic [W-1:0] ea,
  output logic [W-1:0] mar_addr
);
  logic [W-1:0] offset;

  eapc_offset_gen #(.W(W), .SHORT_W(SHORT_W), .MID_W(MID_W), .LONG_W(LONG_W)) u_off (
    .instr(ir), .sel(off_sel), .offset(offset)
  );

  eapc_adder #(.W(W)) u_add (
    .pc(pc), .reg_base(reg_base), .base_sel(base_sel), .offset(offset), .sum(ea)
  );

  eapc_pc_reg #(.W(W), .START_ADDR(START_ADDR)) u_pc (
    .clk(clk), .rst_n(rst_n), .load(pc_load), .sel(pc_sel),
    .bus_in(bus_in), .sum(ea), .pc(pc)
  );

  eapc_addr_mux #(.W(W), .TRAPW(TRAPW)) u_mar (
    .sum(ea), .instr(ir), .sel(addr_sel), .mar_addr(mar_addr)
  );

  always_comb begin
    if (rst_n && off_sel == 2'b00 && !base_sel)
      a_r2_zero_offset_pc: assert (ea == pc);
    if (rst_n && off_sel == 2'b00 && base_sel)
      a_r3_zero_offset_reg: assert (ea == reg_base);
  end

  a_r1_reset_pc: assert property (@(posedge clk) $rose(rst_n) |-> pc == W'(START_ADDR));
endmodule

// File: tb/eapc_unit_tb_top.sv
module eapc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ir = '0, reg_base = '0, bus_in = '0;
  logic        base_sel = 1'b0, pc_load = 1'b0, addr_sel = 1'b0;
  logic [1:0]  off_sel = '0, pc_sel = '0;
  logic [15:0] pc, ea, mar_addr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] pc_m;

  always #5 clk = ~clk;

  eapc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ir(ir), .reg_base(reg_base), .bus_in(bus_in),
    .base_sel(base_sel), .off_sel(off_sel), .pc_sel(pc_sel), .pc_load(pc_load),
    .addr_sel(addr_sel), .pc(pc), .ea(ea), .mar_addr(mar_addr)
  );

  function automatic logic [15:0] exp_off(logic [15:0] w, logic [1:0] s);
    case (s)
      2'b00:   return 16'h0000;
      2'b01:   return {{10{w[5]}}, w[5:0]};
      2'b10:   return {{7{w[8]}}, w[8:0]};
      default: return {{5{w[10]}}, w[10:0]};
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic vec(logic [15:0] i_ir, logic [15:0] i_rb, logic [15:0] i_bus,
                     logic i_bs, logic [1:0] i_os, logic [1:0] i_ps,
                     logic i_ld, logic i_as);
    logic [15:0] e_ea, e_next;
    @(negedge clk);
    ir = i_ir; reg_base = i_rb; bus_in = i_bus; base_sel = i_bs;
    off_sel = i_os; pc_sel = i_ps; pc_load = i_ld; addr_sel = i_as;
    #1;
    e_ea = (i_bs ? i_rb : pc_m) + exp_off(i_ir, i_os);
    chk(i_bs ? "R3 ea reg base" : "R2 ea pc base", ea, e_ea);
    chk("R8 mar_addr", mar_addr, i_as ? {8'h00, i_ir[7:0]} : e_ea);
    if (!i_ld)             e_next = pc_m;
    else if (i_ps == 2'b01) e_next = i_bus;
    else if (i_ps == 2'b10) e_next = e_ea;
    else                   e_next = pc_m + 16'd1;
    @(posedge clk);
    #1;
    if (!i_ld)              chk("R4 pc hold", pc, e_next);
    else if (i_ps == 2'b01) chk("R6 pc bus load", pc, e_next);
    else if (i_ps == 2'b10) chk("R7 pc sum load", pc, e_next);
    else                    chk("R5 pc increment", pc, e_next);
    pc_m = e_next;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", pc, 16'h3000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 pc after reset", pc, 16'h3000);
    pc_m = 16'h3000;

    // R5 fetch increment, R4 hold while bus toggles
    vec(16'h1234, 16'h0, 16'h0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0);
    vec(16'h0, 16'h0, 16'hDEAD, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0);
    vec(16'h0, 16'h0, 16'hBEEF, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0);
    // R6 then R5 wrap from FFFF, code 11 also increments
    vec(16'h0, 16'h0, 16'hFFFF, 1'b0, 2'b00, 2'b01, 1'b1, 1'b0);
    vec(16'h0, 16'h0, 16'h0, 1'b0, 2'b00, 2'b11, 1'b1, 1'b0);
    // R2 all-ones fields for each width, R7 branch using them
    vec(16'hFFFF, 16'h0, 16'h0, 1'b0, 2'b01, 2'b10, 1'b1, 1'b0);
    vec(16'hFFFF, 16'h0, 16'h0, 1'b0, 2'b10, 2'b10, 1'b1, 1'b0);
    vec(16'hFFFF, 16'h0, 16'h0, 1'b0, 2'b11, 2'b10, 1'b1, 1'b0);
    vec(16'hF820, 16'h0, 16'h0, 1'b0, 2'b11, 2'b10, 1'b1, 1'b0);
    // R3 register base, R8 trap vector with high bits set
    vec(16'h003F, 16'h7FFF, 16'h0, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0);
    vec(16'hABCD, 16'h1111, 16'h0, 1'b1, 2'b10, 2'b00, 1'b0, 1'b1);
    vec(16'hF0FF, 16'h0, 16'h0, 1'b0, 2'b11, 2'b00, 1'b0, 1'b1);

    for (int k = 0; k < 400; k++) begin
      vec(16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
          2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule